// File: doc/BRIEF.md
# Synchronous Multi-Ratio Clock Divider

This block turns one input clock into three divided clocks: a fast, a middle and a slow tap. Their shared rising edges fall on the same input edge. A select line picks the ratio set. With the select high, the taps divide by 1, 2 and 3. With the select low, they divide by 2, 4 and 6. Every tap is decoded from one phase counter, so all taps advance on the same input edge and stay in step.

A common enable is sampled on the falling edge of the input clock, so starting and stopping always happens while the clock is low. Once running, the taps only stop at the end of a full frame. A frame is 6 input cycles with the select high and 12 with the select low. At that point every tap is low, so no pulse is ever cut short.

An asynchronous master reset brings every stage to a known, aligned state. The select is captured once after each reset. Later changes to the select wait for the next reset.

Top module: `sync_ratio_divider`

## Requirements
- R1: While the master reset (active high, asynchronous) is asserted, all three taps are low and the phase counter is cleared, whatever the clock, enable and select do.
- R2: With the select captured as 0, counting input cycles from phase 0:
  - the fast tap is high when phase mod 2 = 0;
  - the middle tap is high when phase mod 4 < 2;
  - the slow tap is high when phase mod 6 < 3.
- R3: With the select captured as 1:
  - the fast tap copies the input clock (high only during its high half) for every running cycle;
  - the middle tap is high when phase mod 2 = 0;
  - the slow tap is high when phase mod 3 = 0, which gives 1 cycle high and 2 low.
- R4: At the first input cycle of every frame (every 6 cycles with select 1, every 12 with select 0), all three taps are high together.
- R5: The taps stay low until a falling clock edge samples the enable high. They then start from phase 0 on the very next rising edge.
- R6: A disable takes effect only after the last cycle of the current frame. From then on all taps hold low, and every pulse a tap produces has exactly its nominal high time.
- R7: The select is captured on the first rising edge after reset is released. The taps cannot start before the rising edge after that one. Changes to the select after capture have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| mrst_i | input | 1 | Asynchronous master reset, active high |
| fsel_i | input | 1 | Ratio set select: 1 gives /1,/2,/3; 0 gives /2,/4,/6 |
| en_i | input | 1 | Common enable, sampled on the falling clock edge |
| div_fast_o | output | 1 | Fastest tap (/1 or /2) |
| div_mid_o | output | 1 | Middle tap (/2 or /4) |
| div_slow_o | output | 1 | Slowest tap (/3 or /6) |

## Verification
The bench sweeps the cycle at which the enable is dropped over every position in the first two frames, for both ratio sets. Each sample, taken in both halves of every input cycle, is compared with a phase-modulo formula. This separates a wrong frame boundary, a wrong tap ratio and a stop that cuts a pulse short.

Several further patterns are used:
- An enable already high at reset release shows whether the capture edge is respected.
- A select flip without reset shows that the ratio set stays latched.
- A reset in mid-frame shows that the taps drop at once.

A pulse-width monitor measures every high pulse in half-cycle units. This catches any shortened pulse that the pattern checks might place differently.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  typedef enum logic {RATIO_LO = 1'b0, RATIO_HI = 1'b1} ratio_e;

  localparam int unsigned NUM_TAPS = 3;

  // Divide ratio and high time (in input cycles) per tap, fast tap first.
  localparam int unsigned HI_DIV  [NUM_TAPS] = '{1, 2, 3};
  localparam int unsigned HI_HIGH [NUM_TAPS] = '{1, 1, 1};
  localparam int unsigned LO_DIV  [NUM_TAPS] = '{2, 4, 6};
  localparam int unsigned LO_HIGH [NUM_TAPS] = '{1, 2, 3};

  // Frame = common period of all taps in a ratio set.
  localparam int unsigned FRAME_HI = 6;
  localparam int unsigned FRAME_LO = 12;

  function automatic logic tap_on(input int unsigned phase,
                                  input int unsigned ratio,
                                  input int unsigned high);
    return (phase % ratio) < high;
  endfunction

endpackage

// File: rtl/clkdiv_en_gate.sv
`timescale 1ns/1ps
// Falling-edge enable capture plus the gate used by the pass-through tap.
module clkdiv_en_gate (
  input  logic clk_i,
  input  logic mrst_i,
  input  logic en_i,
  input  logic locked_i,
  input  logic run_i,
  input  logic last_i,
  output logic en_q_o,
  output logic gate_o
);

  logic gate_d;

  // Predict whether the sequencer will be running after the next rising edge.
  always_comb begin
    if (run_i) gate_d = locked_i & ~(last_i & ~en_i);
    else       gate_d = locked_i & en_i;
  end

  always_ff @(negedge clk_i or posedge mrst_i) begin
    if (mrst_i) begin
      en_q_o <= 1'b0;
      gate_o <= 1'b0;
    end else begin
      en_q_o <= en_i;
      gate_o <= gate_d;
    end
  end

endmodule

// File: rtl/clkdiv_frame_seq.sv
`timescale 1ns/1ps
// Shared phase counter: captures the ratio set, starts on enable,
// stops only at a frame boundary.
module clkdiv_frame_seq
  import clkdiv_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk_i,
  input  logic            mrst_i,
  input  logic            fsel_i,
  input  logic            en_q_i,
  output logic            locked_o,
  output ratio_e          mode_o,
  output logic            run_o,
  output logic [PH_W-1:0] ph_o,
  output logic            last_o
);

  localparam logic [PH_W-1:0] LAST_HI = PH_W'(FRAME_HI - 1);
  localparam logic [PH_W-1:0] LAST_LO = PH_W'(FRAME_LO - 1);

  logic [PH_W-1:0] frame_last;

  assign frame_last = (mode_o == RATIO_HI) ? LAST_HI : LAST_LO;
  assign last_o     = run_o & (ph_o == frame_last);

  always_ff @(posedge clk_i or posedge mrst_i) begin
    if (mrst_i) begin
      locked_o <= 1'b0;
      mode_o   <= RATIO_LO;
      run_o    <= 1'b0;
      ph_o     <= '0;
    end else if (!locked_o) begin
      locked_o <= 1'b1;
      mode_o   <= ratio_e'(fsel_i);
    end else if (!run_o) begin
      if (en_q_i) begin
        run_o <= 1'b1;
        ph_o  <= '0;
      end
    end else if (ph_o == frame_last) begin
      ph_o <= '0;
      if (!en_q_i) run_o <= 1'b0;
    end else begin
      ph_o <= ph_o + 1'b1;
    end
  end

endmodule

// File: rtl/clkdiv_taps.sv
`timescale 1ns/1ps
// Decodes each output tap from the shared phase.
module clkdiv_taps
  import clkdiv_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic                clk_i,
  input  logic                gate_i,
  input  ratio_e              mode_i,
  input  logic                run_i,
  input  logic [PH_W-1:0]     ph_i,
  output logic [NUM_TAPS-1:0] q_o
);

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    logic lo_q;
    logic hi_q;

    assign lo_q = run_i & tap_on(32'(ph_i), LO_DIV[t], LO_HIGH[t]);

    if (HI_DIV[t] == 1) begin : g_pass
      // Gate changes only while the clock is low: whole pulses only.
      assign hi_q = clk_i & gate_i;
    end else begin : g_cnt
      assign hi_q = run_i & tap_on(32'(ph_i), HI_DIV[t], HI_HIGH[t]);
    end

    assign q_o[t] = (mode_i == RATIO_HI) ? hi_q : lo_q;
  end

endmodule

// File: rtl/sync_ratio_divider.sv
`timescale 1ns/1ps
module sync_ratio_divider
  import clkdiv_pkg::*;
#(
  parameter int PH_W = $clog2(FRAME_LO)
) (
  input  logic clk_i,
  input  logic mrst_i,
  input  logic fsel_i,
  input  logic en_i,
  output logic div_fast_o,
  output logic div_mid_o,
  output logic div_slow_o
);

  logic            en_q;
  logic            gate_q;
  logic            locked_q;
  ratio_e          mode_q;
  logic            run_q;
  logic [PH_W-1:0] ph_q;
  logic            last_w;
  logic [NUM_TAPS-1:0] taps;

  clkdiv_en_gate u_en (
    .clk_i    (clk_i),
    .mrst_i   (mrst_i),
    .en_i     (en_i),
    .locked_i (locked_q),
    .run_i    (run_q),
    .last_i   (last_w),
    .en_q_o   (en_q),
    .gate_o   (gate_q)
  );

  clkdiv_frame_seq #(.PH_W(PH_W)) u_seq (
    .clk_i    (clk_i),
    .mrst_i   (mrst_i),
    .fsel_i   (fsel_i),
    .en_q_i   (en_q),
    .locked_o (locked_q),
    .mode_o   (mode_q),
    .run_o    (run_q),
    .ph_o     (ph_q),
    .last_o   (last_w)
  );

  clkdiv_taps #(.PH_W(PH_W)) u_taps (
    .clk_i  (clk_i),
    .gate_i (gate_q),
    .mode_i (mode_q),
    .run_i  (run_q),
    .ph_i   (ph_q),
    .q_o    (taps)
  );

  assign div_fast_o = taps[0];
  assign div_mid_o  = taps[1];
  assign div_slow_o = taps[2];

endmodule

// File: rtl/clkdiv_checks.sv
`timescale 1ns/1ps
module clkdiv_checks
  import clkdiv_pkg::*;
#(
  parameter int PH_W = 4
) (
  input logic            clk_i,
  input logic            mrst_i,
  input logic            div_fast_o,
  input logic            div_mid_o,
  input logic            div_slow_o,
  input logic            run_i,
  input logic [PH_W-1:0] ph_i,
  input ratio_e          mode_i,
  input logic            locked_i
);

  localparam logic [PH_W-1:0] LAST_HI = PH_W'(FRAME_HI - 1);
  localparam logic [PH_W-1:0] LAST_LO = PH_W'(FRAME_LO - 1);

  always @(negedge clk_i) begin
    if (mrst_i) begin
      AST_RESET_LOW: assert (!div_fast_o && !div_mid_o && !div_slow_o); // R1
    end
  end

  AST_PH_IN_FRAME: assert property (@(posedge clk_i) disable iff (mrst_i)
    ph_i <= ((mode_i == RATIO_HI) ? LAST_HI : LAST_LO)); // R4

  AST_FRAME_START_HIGH: assert property (@(posedge clk_i) disable iff (mrst_i)
    (run_i && ph_i == '0) |-> (div_mid_o && div_slow_o)); // R4

  AST_START_AT_ZERO: assert property (@(posedge clk_i) disable iff (mrst_i)
    $rose(run_i) |-> (ph_i == '0)); // R5

  AST_STOP_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (mrst_i)
    $fell(run_i) |-> ($past(ph_i) == ((mode_i == RATIO_HI) ? LAST_HI : LAST_LO))); // R6

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (mrst_i)
    locked_i |=> (locked_i && $stable(mode_i))); // R7

endmodule

bind sync_ratio_divider clkdiv_checks #(.PH_W(PH_W)) u_chk (
  .clk_i      (clk_i),
  .mrst_i     (mrst_i),
  .div_fast_o (div_fast_o),
  .div_mid_o  (div_mid_o),
  .div_slow_o (div_slow_o),
  .run_i      (run_q),
  .ph_i       (ph_q),
  .mode_i     (mode_q),
  .locked_i   (locked_q)
);

// File: tb/sim_sync_ratio_divider.sv
`timescale 1ns/1ps
module sim_sync_ratio_divider;

  logic clk = 1'b0;
  logic mrst, fsel, en;
  logic fast, mid, slow;
  logic [2:0] outs;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  bit  mon_hi = 1'b1;
  int  run_len [3] = '{0, 0, 0};

  always #10 clk = ~clk;

  sync_ratio_divider u0 (
    .clk_i      (clk),
    .mrst_i     (mrst),
    .fsel_i     (fsel),
    .en_i       (en),
    .div_fast_o (fast),
    .div_mid_o  (mid),
    .div_slow_o (slow)
  );

  assign outs = {slow, mid, fast};

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected tap level from the requirement formulas.
  function automatic int exp_out(input int t, input bit hi, input int k, input bit high_half);
    if (hi) begin
      case (t)
        0:       return high_half ? 1 : 0;
        1:       return (k % 2) < 1 ? 1 : 0;
        default: return (k % 3) < 1 ? 1 : 0;
      endcase
    end else begin
      case (t)
        0:       return (k % 2) < 1 ? 1 : 0;
        1:       return (k % 4) < 2 ? 1 : 0;
        default: return (k % 6) < 3 ? 1 : 0;
      endcase
    end
  endfunction

  // Nominal high time in half-cycle samples.
  function automatic int nominal(input int t, input bit hi);
    if (hi) return (t == 0) ? 1 : 2;
    return (t == 0) ? 2 : ((t == 1) ? 4 : 6);
  endfunction

  // Pulse-width monitor: every completed pulse must have its nominal width (R6).
  task automatic mon_sample();
    for (int t = 0; t < 3; t++) begin
      if (mrst) run_len[t] = 0;
      else if (outs[t]) run_len[t]++;
      else if (run_len[t] > 0) begin
        chk(run_len[t] == nominal(t, mon_hi), "R6",
            $sformatf("pulse width tap %0d", t), run_len[t], nominal(t, mon_hi));
        run_len[t] = 0;
      end
    end
  endtask

  always begin
    @(posedge clk); #5; mon_sample();
    @(negedge clk); #5; mon_sample();
  end

  task automatic check_taps(input bit hi, input int k, input bit high_half,
                            input bit active, input string tag);
    string req;
    int e;
    for (int t = 0; t < 3; t++) begin
      e = active ? exp_out(t, hi, k, high_half) : 0;
      if (!active) req = "R6";
      else if (tag != "") req = tag;
      else req = hi ? "R3" : "R2";
      chk(int'(outs[t]) == e, req,
          $sformatf("tap %0d phase %0d half %0d", t, k, high_half), int'(outs[t]), e);
    end
  endtask

  task automatic do_reset(input bit hi);
    @(posedge clk); #3;
    mrst = 1'b1; fsel = hi; en = 1'b0; mon_hi = hi;
    @(posedge clk); #5;
    chk(outs == 3'b000, "R1", "taps in reset (clk high)", int'(outs), 0);
    @(negedge clk); #5;
    chk(outs == 3'b000, "R1", "taps in reset (clk low)", int'(outs), 0);
    @(posedge clk); #3;
    mrst = 1'b0;
    @(posedge clk); #3;
  endtask

  task automatic run_window(input bit hi, input int stop_j, input string tag);
    int len  = hi ? 6 : 12;
    int endc = ((stop_j + 1) / len + 1) * len - 1;
    @(posedge clk); #3;
    en = 1'b1;
    #2;
    chk(outs == 3'b000, "R5", "no output before falling-edge sample", int'(outs), 0);
    for (int k = 0; k <= endc + 3; k++) begin
      @(posedge clk); #5;
      check_taps(hi, k, 1'b1, k <= endc, tag);
      if (k <= endc && (k % len) == 0)
        chk(outs == 3'b111, "R4", $sformatf("frame start phase %0d", k), int'(outs), 7);
      @(negedge clk); #5;
      check_taps(hi, k, 1'b0, k <= endc, tag);
      if (k == stop_j) en = 1'b0;
    end
  endtask

  task automatic early_start(input bit hi);
    int len = hi ? 6 : 12;
    @(posedge clk); #3;
    mrst = 1'b1; fsel = hi; en = 1'b1; mon_hi = hi;
    repeat (2) @(posedge clk);
    #3 mrst = 1'b0;
    @(posedge clk); #5;
    chk(outs == 3'b000, "R7", "no start on capture edge", int'(outs), 0);
    @(posedge clk); #5;
    chk(outs == 3'b111, "R7", "start on edge after capture", int'(outs), 7);
    en = 1'b0;
    repeat (2 * len) @(posedge clk);
    #5;
    chk(outs == 3'b000, "R6", "stopped after early start", int'(outs), 0);
  endtask

  task automatic reset_midrun();
    @(posedge clk); #3;
    en = 1'b1;
    repeat (4) @(posedge clk);
    #3 mrst = 1'b1;
    #2;
    chk(outs == 3'b000, "R1", "taps drop on mid-frame reset", int'(outs), 0);
    en = 1'b0;
    @(negedge clk); #5;
    chk(outs == 3'b000, "R1", "taps held in reset", int'(outs), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mrst = 1'b1; fsel = 1'b1; en = 1'b0;
    do_reset(1'b1);                                        // R1
    early_start(1'b1);                                     // R7
    do_reset(1'b1);
    for (int j = 0; j <= 10; j++) run_window(1'b1, j, ""); // R3 R4 R5 R6
    fsel = 1'b0;
    run_window(1'b1, 7, "R7");                             // select change ignored
    reset_midrun();                                        // R1
    do_reset(1'b0);
    for (int j = 0; j <= 22; j++) run_window(1'b0, j, ""); // R2 R4 R5 R6
    reset_midrun();
    early_start(1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule